// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit collects the interrupt conditions of one UART channel and resolves them into one identification code. The code names the highest-priority source that is both pending and enabled. An active-high interrupt request accompanies the code. The unit holds the sticky pending flags for the edge- and pulse-type conditions and applies each source's own clear rule. It does this from decoded register-access strobes and from status levels supplied by the FIFOs, the modem-control logic and the flow-control logic around it.

Two sources are levels and pass straight through. These are the receive error summary and receive data available. Every other source is a one-cycle event, or an edge on a level, that sets a pending flag on a clock edge. An identification read clears only the source whose code is on the output in that cycle. All pins are plain control and status signals. No data stream passes through the unit, so it has no valid/ready handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and with `cts_n_i`, `rts_n_i` high and `tx_room_i` low, the code is 000001 and `irq_o` is low.
- R2: Line status (enable bit 2) gives code 000110 and outranks every other source. It is pending while `rx_err_i` is high, or from a `rx_ovr_i` pulse until an `lsr_rd_i` strobe.
- R3: A `rx_tout_i` pulse (enable bit 0) sets a timeout flag with code 000110's neighbour 001100. This flag outranks receive data available and is cleared by `rhr_rd_i`.
- R4: Receive data available (enable bit 0) gives code 000100 for as long as `rx_avail_i` is high.
- R5: A rising edge of `tx_room_i` (enable bit 1) sets transmit-empty with code 000010. The flag is cleared by `thr_wr_i`, or by `iir_rd_i` while 000010 is the reported code.
- R6: An `iir_rd_i` strobe issued while a higher-priority code is shown leaves a lower-priority flag pending.
- R7: A pulse on any bit of `msr_delta_i` (enable bit 3) sets modem status with code 000000. The flag is cleared by `msr_rd_i`.
- R8: A `xoff_det_i` pulse (enable bit 5) sets a flag with code 010000. The flag is cleared by `xon_det_i` and not by `lsr_rd_i`.
- R9: A `spec_det_i` pulse (enable bit 5) sets a flag with code 010000. The flag is cleared by `lsr_rd_i` and not by `xon_det_i`.
- R10: A low-to-high transition on `cts_n_i` (enable bit 7) or `rts_n_i` (enable bit 6) sets a flag with code 100000. A high-to-low transition sets nothing. An `iir_rd_i` strobe while 100000 is reported clears the enabled flags of this level.
- R11: A disabled source never shows in the code and never raises `irq_o`. Its flag stays latched and shows once it is enabled. Enable bit 4 has no effect.
- R12: `irq_o` is high exactly when code bit 0 is 0. An event sets its flag on the clock edge that samples it, and the flag is visible after that edge. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_i | input | 8 | Interrupt enable bits |
| rx_err_i | input | 1 | Error present somewhere in the receive FIFO (level) |
| rx_ovr_i | input | 1 | Overrun event (pulse) |
| rx_tout_i | input | 1 | Receive timeout event (pulse) |
| rx_avail_i | input | 1 | Data ready / receive FIFO above trigger (level) |
| tx_room_i | input | 1 | Holding register empty / transmit FIFO past trigger (level) |
| msr_delta_i | input | MSR_W | Modem status change events (pulses) |
| xoff_det_i | input | 1 | Xoff character detected (pulse) |
| xon_det_i | input | 1 | Xon character detected (pulse) |
| spec_det_i | input | 1 | Special character detected (pulse) |
| cts_n_i | input | 1 | CTS pin level, active low |
| rts_n_i | input | 1 | RTS pin level, active low |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_code_o | output | 6 | Identification code of the reported source |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default of four modem-change inputs. At that width, a pulse on a single middle bit can be shown to set the modem flag, which checks the OR reduction over the whole vector. The full 8-bit enable register is driven. This makes it possible to show that the unused bit 4 is inert, that each source can be masked on its own, and that the CTS and RTS enables mask the shared level independently. The directed part covers the cases where a strobe clears one flag but not another: an identification read under a higher-priority source, and the pair of clear rules that share code 010000.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_LAT = 8;
  localparam int NUM_LVL = 7;

  // sticky flag slots
  localparam int L_TOUT = 0;
  localparam int L_TX   = 1;
  localparam int L_MSR  = 2;
  localparam int L_XOFF = 3;
  localparam int L_SPEC = 4;
  localparam int L_RTS  = 5;
  localparam int L_CTS  = 6;
  localparam int L_OVR  = 7;

  // request slots, index 0 is the highest priority
  localparam int Q_LS   = 0;
  localparam int Q_TOUT = 1;
  localparam int Q_RXD  = 2;
  localparam int Q_TX   = 3;
  localparam int Q_MSR  = 4;
  localparam int Q_XS   = 5;
  localparam int Q_FLOW = 6;

  localparam logic [5:0] C_NONE = 6'b000001;
  localparam logic [5:0] C_LS   = 6'b000110;
  localparam logic [5:0] C_TOUT = 6'b001100;
  localparam logic [5:0] C_RXD  = 6'b000100;
  localparam logic [5:0] C_TX   = 6'b000010;
  localparam logic [5:0] C_MSR  = 6'b000000;
  localparam logic [5:0] C_XS   = 6'b010000;
  localparam logic [5:0] C_FLOW = 6'b100000;

  function automatic logic [5:0] lvl_code(input int idx);
    case (idx)
      Q_LS:    return C_LS;
      Q_TOUT:  return C_TOUT;
      Q_RXD:   return C_RXD;
      Q_TX:    return C_TX;
      Q_MSR:   return C_MSR;
      Q_XS:    return C_XS;
      Q_FLOW:  return C_FLOW;
      default: return C_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_rise.sv
module uart_irq_rise #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = rst_n ? (lvl_i & ~prev_q) : '0;
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_LVL-1:0] req_i,
  output logic [5:0]         code_o,
  output logic               any_o
);
  always_comb begin
    code_o = C_NONE;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = lvl_code(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ier_i,
  input  logic             rx_err_i,
  input  logic             rx_ovr_i,
  input  logic             rx_tout_i,
  input  logic             rx_avail_i,
  input  logic             tx_room_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             xoff_det_i,
  input  logic             xon_det_i,
  input  logic             spec_det_i,
  input  logic             cts_n_i,
  input  logic             rts_n_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             rhr_rd_i,
  input  logic             thr_wr_i,
  output logic [5:0]       iir_code_o,
  output logic             irq_o
);
  localparam int NE = 3;  // edge inputs: tx room, rts, cts

  logic [NE-1:0]      edge_lvl, edge_rise;
  logic [NUM_LAT-1:0] lat_set, lat_clr, pend;
  logic [NUM_LVL-1:0] req;
  logic               rep_tx, rep_flow;
  logic               tx_rise, rts_rise, cts_rise;

  assign edge_lvl = {cts_n_i, rts_n_i, tx_room_i};

  uart_irq_rise #(.W(NE), .RST_VAL(3'b110)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl_i(edge_lvl), .rise_o(edge_rise)
  );

  assign tx_rise  = edge_rise[0];
  assign rts_rise = edge_rise[1];
  assign cts_rise = edge_rise[2];

  // the code shown in this cycle is what an identification read returns
  assign rep_tx   = iir_rd_i && (iir_code_o == C_TX);
  assign rep_flow = iir_rd_i && (iir_code_o == C_FLOW);

  always_comb begin
    lat_set         = '0;
    lat_clr         = '0;
    lat_set[L_TOUT] = rx_tout_i;
    lat_clr[L_TOUT] = rhr_rd_i;
    lat_set[L_TX]   = tx_rise;
    lat_clr[L_TX]   = thr_wr_i | rep_tx;
    lat_set[L_MSR]  = |msr_delta_i;
    lat_clr[L_MSR]  = msr_rd_i;
    lat_set[L_XOFF] = xoff_det_i;
    lat_clr[L_XOFF] = xon_det_i;
    lat_set[L_SPEC] = spec_det_i;
    lat_clr[L_SPEC] = lsr_rd_i;
    lat_set[L_RTS]  = rts_rise;
    lat_clr[L_RTS]  = rep_flow & ier_i[6];
    lat_set[L_CTS]  = cts_rise;
    lat_clr[L_CTS]  = rep_flow & ier_i[7];
    lat_set[L_OVR]  = rx_ovr_i;
    lat_clr[L_OVR]  = lsr_rd_i;
  end

  uart_irq_sticky #(.N(NUM_LAT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(lat_set), .clr_i(lat_clr), .q_o(pend)
  );

  always_comb begin
    req         = '0;
    req[Q_LS]   = ier_i[2] & (rx_err_i | pend[L_OVR]);
    req[Q_TOUT] = ier_i[0] & pend[L_TOUT];
    req[Q_RXD]  = ier_i[0] & rx_avail_i;
    req[Q_TX]   = ier_i[1] & pend[L_TX];
    req[Q_MSR]  = ier_i[3] & pend[L_MSR];
    req[Q_XS]   = ier_i[5] & (pend[L_XOFF] | pend[L_SPEC]);
    req[Q_FLOW] = (ier_i[6] & pend[L_RTS]) | (ier_i[7] & pend[L_CTS]);
  end

  uart_irq_prio u_prio (.req_i(req), .code_o(iir_code_o), .any_o(irq_o));

  // R12: request and code agree
  a_r12_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !iir_code_o[0]);

  // R11: nothing enabled means no request
  a_r11_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i == 8'h00) |-> !irq_o);

  // R8: Xon clears the Xoff flag
  a_r8_xon_clears_xoff: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_det_i && !xoff_det_i) |=> !pend[L_XOFF]);

  // R5: holding register write clears transmit empty
  a_r5_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !tx_rise) |=> !pend[L_TX]);

  // R6: a read that reports another code leaves transmit empty pending
  a_r6_iir_keeps_unreported: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && pend[L_TX] && iir_code_o != C_TX && !thr_wr_i) |=> pend[L_TX]);

  // R10: CTS deassertion sets its flag
  a_r10_cts_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_n_i && !$past(cts_n_i) && $past(rst_n)) |=> pend[L_CTS]);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ier = 8'h00;
  logic rx_err = 0, rx_ovr = 0, rx_tout = 0, rx_avail = 0, tx_room = 0;
  logic [3:0] msr_delta = 4'h0;
  logic xoff = 0, xon = 0, spec = 0, cts_n = 1, rts_n = 1;
  logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic [5:0] code;
  logic       irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.MSR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .rx_err_i(rx_err), .rx_ovr_i(rx_ovr),
    .rx_tout_i(rx_tout), .rx_avail_i(rx_avail), .tx_room_i(tx_room),
    .msr_delta_i(msr_delta), .xoff_det_i(xoff), .xon_det_i(xon), .spec_det_i(spec),
    .cts_n_i(cts_n), .rts_n_i(rts_n), .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd),
    .msr_rd_i(msr_rd), .rhr_rd_i(rhr_rd), .thr_wr_i(thr_wr),
    .iir_code_o(code), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] en;
    logic       err;
    logic       avail;
    logic [5:0] exp_code;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 1'b1, 1'b1, 6'b000001, 1'b0},  // R11 all masked
    '{8'h01, 1'b1, 1'b1, 6'b000100, 1'b1},  // R4
    '{8'h04, 1'b1, 1'b1, 6'b000110, 1'b1},  // R2
    '{8'h05, 1'b1, 1'b1, 6'b000110, 1'b1},  // R2 priority
    '{8'h05, 1'b0, 1'b1, 6'b000100, 1'b1},  // R4
    '{8'h10, 1'b1, 1'b1, 6'b000001, 1'b0},  // R11 bit 4 inert
    '{8'hFB, 1'b1, 1'b1, 6'b000100, 1'b1},  // R11 bit 2 off
    '{8'hFF, 1'b0, 1'b0, 6'b000001, 1'b0}   // R12 idle
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [5:0] exp_code);
    logic exp_irq;
    exp_irq = !exp_code[0];
    n_chk++;
    if (code !== exp_code || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, code, irq, exp_code, exp_irq);
    end
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    chk("R1", 6'b000001);
    ier = 8'hFF; #1;
    chk("R1", 6'b000001);

    foreach (VECS[i]) begin
      ier = VECS[i].en; rx_err = VECS[i].err; rx_avail = VECS[i].avail;
      #1;
      n_chk++;
      if (code !== VECS[i].exp_code || irq !== VECS[i].exp_irq) begin
        n_bad++;
        $display("FAIL R2/R4/R11 vector %0d: code=%b irq=%b expected code=%b irq=%b",
                 i, code, irq, VECS[i].exp_code, VECS[i].exp_irq);
      end
      step();
    end

    ier = 8'hFF; rx_err = 0; rx_avail = 0;
    // R3 timeout over data available, cleared by RHR read
    rx_avail = 1; rx_tout = 1; step(); rx_tout = 0;
    chk("R3", 6'b001100);
    rhr_rd = 1; step(); rhr_rd = 0;
    chk("R3", 6'b000100);
    rx_avail = 0; #1;
    chk("R4", 6'b000001);

    // R2 overrun latch
    rx_ovr = 1; step(); rx_ovr = 0;
    chk("R2", 6'b000110);
    step();
    chk("R2", 6'b000110);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R2", 6'b000001);

    // R5 transmit empty
    tx_room = 1; step();
    chk("R5", 6'b000010);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R5", 6'b000001);
    tx_room = 0; step(); tx_room = 1; step();
    chk("R5", 6'b000010);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R5", 6'b000001);

    // R6 read under higher priority keeps transmit empty
    tx_room = 0; step(); tx_room = 1; rx_avail = 1; step();
    chk("R6", 6'b000100);
    iir_rd = 1; step(); iir_rd = 0;
    rx_avail = 0; #1;
    chk("R6", 6'b000010);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R6", 6'b000001);

    // R7 modem status
    msr_delta = 4'b0100; step(); msr_delta = 4'h0;
    chk("R7", 6'b000000);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R7", 6'b000001);

    // R8 Xoff
    xoff = 1; step(); xoff = 0;
    chk("R8", 6'b010000);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R8", 6'b010000);
    xon = 1; step(); xon = 0;
    chk("R8", 6'b000001);

    // R9 special character
    spec = 1; step(); spec = 0;
    chk("R9", 6'b010000);
    xon = 1; step(); xon = 0;
    chk("R9", 6'b010000);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R9", 6'b000001);

    // R10 CTS edges
    cts_n = 0; step();
    chk("R10", 6'b000001);
    cts_n = 1; step();
    chk("R10", 6'b100000);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R10", 6'b000001);

    // R10/R11 RTS masked then enabled
    ier = 8'hBF;
    rts_n = 0; step(); rts_n = 1; step();
    chk("R11", 6'b000001);
    ier = 8'hFF; #1;
    chk("R11", 6'b100000);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R10", 6'b000001);

    // R11 masked transmit empty stays latched
    ier = 8'h00;
    tx_room = 0; step(); tx_room = 1; step();
    chk("R11", 6'b000001);
    ier = 8'hFF; #1;
    chk("R11", 6'b000010);

    // R12 set wins over clear in the same cycle
    thr_wr = 1; step(); thr_wr = 0;
    chk("R12", 6'b000001);
    xoff = 1; xon = 1; step(); xoff = 0; xon = 0;
    chk("R12", 6'b010000);
    xon = 1; step(); xon = 0;
    chk("R12", 6'b000001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule